// File: doc/BRIEF.md
# Byte-Lane Register Hazard Tracker

This block sits beside the issue stage of a core whose register file holds 64-bit words with byte write enables. For each register it keeps one pending-write flag per 8-bit lane, plus a flag recording that a full-width write is outstanding. Issue logic presents one request per cycle: a register index, either a whole-word access or a set of byte lanes, and whether the access reads or writes. The tracker answers at once, in the same cycle, with a grant. When it grants nothing, the request must stall. A granted write marks its lanes as pending. A writeback carrying per-byte enables clears exactly the lanes it names.

Because the flags are held per lane, narrow operations on different bytes of the same register can be in flight together. Whole-word accesses still wait until every lane is settled. A predicate consumed lane by lane is issued as eight one-lane reads. Each of those reads is released as soon as its own producing lane is written back, with no wait for the rest of the register. A writeback that arrives in the same cycle as a request is taken into account before the hazard decision and before the new flags are set.

Top module: `byte_hazard_tracker`

## Requirements
- R1: A synchronous active-high reset clears every lane flag and every full-write flag. After reset `reg_busy` is all zero and any non-empty request is granted.
- R2: A granted write with `req_full`=0 sets the flags of the lanes in `req_lanes` (bit k is byte k) for that register. The register's `reg_busy` bit is 1 from the next cycle.
- R3: A request whose lanes are disjoint from all pending lanes of the same register is granted, provided no full-width write to that register is pending.
- R4: A byte-lane read or write that shares any lane with a pending lane of the same register gets `grant`=0.
- R5: A whole-word request (`req_full`=1, read or write) gets `grant`=0 while any lane of that register is pending.
- R6: A granted write with `req_full`=1 sets all eight lane flags and the full-write flag. While the full-write flag stands, every request to that register stalls, even on lanes that have already been written back. The flag drops once the last lane is cleared.
- R7: A writeback (`wb_valid`=1) clears only the lane flags whose bit is set in `wb_be` for register `wb_idx`. The other lanes stay pending.
- R8: A writeback in the same cycle as a request is applied first. A request to a lane freed by that writeback is granted, and a granted write then leaves that lane pending.
- R9: A granted read changes no flag.
- R10: With `req_valid`=0, or with `req_full`=0 and `req_lanes`=0, `grant` is 0 and no flag is set.
- R11: Eight single-lane reads of one register are each granted as soon as their own lane is written back, in whatever order the writebacks arrive. A lane not yet written back stays stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Issue request present |
| req_idx | input | 3 | Register index of the request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_full | input | 1 | 1 = whole-word access, 0 = byte lanes in `req_lanes` |
| req_lanes | input | 8 | Byte lanes of a narrow access, bit k = byte k |
| grant | output | 1 | Combinational: request may issue this cycle |
| wb_valid | input | 1 | Writeback present |
| wb_idx | input | 3 | Register index of the writeback |
| wb_be | input | 8 | Byte enables of the writeback, bit k clears lane k |
| reg_busy | output | 8 | Per register: any lane or full-write flag pending |

## Verification
Directed sequences separate the cases that a per-register flag cannot tell apart. Writes to disjoint lanes of one register must both be granted, while a same-lane read must stall. A whole-word read must stay blocked by a single remaining lane. A full-width write must keep blocking narrow requests after a partial writeback. A writeback and an issue to the same lane in one cycle show that the clear is applied before the set. Eight lane reads released by writebacks in a scrambled order show that lanes are tracked one by one. A long run of seeded random requests and writebacks, including narrow, full, empty and idle requests, is then compared every cycle against a scoreboard of lane and full flags kept in the bench.

// File: rtl/bht_pkg.sv
package bht_pkg;

  // Kind of access presented by issue logic
  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_e;

  localparam int unsigned BHT_DEF_REGS  = 8;
  localparam int unsigned BHT_DEF_LANES = 8;

endpackage

// File: rtl/bht_lane_state.sv
module bht_lane_state #(
  parameter int unsigned LANES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wb_hit_i,
  input  logic [LANES-1:0] wb_be_i,
  input  logic             set_en_i,
  input  logic [LANES-1:0] set_mask_i,
  input  logic             set_full_i,
  output logic [LANES-1:0] eff_lanes_o,
  output logic             eff_full_o,
  output logic             busy_o
);

  logic [LANES-1:0] lane_q;
  logic             full_q;
  logic [LANES-1:0] clr_mask;

  // Writeback clear is seen before any new issue
  assign clr_mask    = wb_hit_i ? wb_be_i : '0;
  assign eff_lanes_o = lane_q & ~clr_mask;
  assign eff_full_o  = full_q & (|eff_lanes_o);
  assign busy_o      = (|lane_q) | full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_q <= '0;
      full_q <= 1'b0;
    end else if (set_en_i) begin
      lane_q <= eff_lanes_o | set_mask_i;
      full_q <= eff_full_o | set_full_i;
    end else begin
      lane_q <= eff_lanes_o;
      full_q <= eff_full_o;
    end
  end

  // R6
  full_needs_lane_chk: assert property (@(posedge clk) disable iff (rst)
    full_q |-> (|lane_q));

  // R2
  set_marks_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    set_en_i |=> ((lane_q & $past(set_mask_i)) == $past(set_mask_i)));

  // R7
  wb_clears_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_hit_i && !set_en_i) |=> ((lane_q & $past(wb_be_i)) == '0));

  // R9
  no_set_no_new_chk: assert property (@(posedge clk) disable iff (rst)
    !set_en_i |=> ((lane_q & ~$past(lane_q)) == '0));

endmodule

// File: rtl/bht_hazard_check.sv
module bht_hazard_check #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned LANES    = 8,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             req_valid_i,
  input  logic [IDX_W-1:0]                 req_idx_i,
  input  logic                             req_full_i,
  input  logic [LANES-1:0]                 req_lanes_i,
  input  logic [NUM_REGS-1:0][LANES-1:0]   eff_lanes_i,
  input  logic [NUM_REGS-1:0]              eff_full_i,
  output logic [LANES-1:0]                 req_mask_o,
  output logic                             grant_o
);

  logic [LANES-1:0] sel_lanes;
  logic             sel_full;
  logic             conflict;

  assign req_mask_o = req_full_i ? {LANES{1'b1}} : req_lanes_i;
  assign sel_lanes  = eff_lanes_i[req_idx_i];
  assign sel_full   = eff_full_i[req_idx_i];
  assign conflict   = (|(sel_lanes & req_mask_o)) | sel_full;
  assign grant_o    = req_valid_i & (|req_mask_o) & ~conflict;

  // R5
  full_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_o && req_full_i) |-> (eff_lanes_i[req_idx_i] == '0));

  // R10
  idle_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_valid_i || (!req_full_i && req_lanes_i == '0)) |-> !grant_o);

endmodule

// File: rtl/byte_hazard_tracker.sv
module byte_hazard_tracker #(
  parameter int unsigned NUM_REGS = bht_pkg::BHT_DEF_REGS,
  parameter int unsigned LANES    = bht_pkg::BHT_DEF_LANES,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [IDX_W-1:0]    req_idx,
  input  logic                req_write,
  input  logic                req_full,
  input  logic [LANES-1:0]    req_lanes,
  output logic                grant,
  input  logic                wb_valid,
  input  logic [IDX_W-1:0]    wb_idx,
  input  logic [LANES-1:0]    wb_be,
  output logic [NUM_REGS-1:0] reg_busy
);

  import bht_pkg::*;

  logic [NUM_REGS-1:0][LANES-1:0] eff_lanes;
  logic [NUM_REGS-1:0]            eff_full;
  logic [LANES-1:0]               req_mask;
  acc_e                           acc_kind;

  assign acc_kind = req_write ? ACC_WRITE : ACC_READ;

  bht_hazard_check #(
    .NUM_REGS(NUM_REGS),
    .LANES   (LANES)
  ) hazard_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid_i(req_valid),
    .req_idx_i  (req_idx),
    .req_full_i (req_full),
    .req_lanes_i(req_lanes),
    .eff_lanes_i(eff_lanes),
    .eff_full_i (eff_full),
    .req_mask_o (req_mask),
    .grant_o    (grant)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic wb_hit;
    logic set_en;

    assign wb_hit = wb_valid && (wb_idx == IDX_W'(r));
    assign set_en = grant && (acc_kind == ACC_WRITE) && (req_idx == IDX_W'(r));

    bht_lane_state #(
      .LANES(LANES)
    ) state_i (
      .clk        (clk),
      .rst        (rst),
      .wb_hit_i   (wb_hit),
      .wb_be_i    (wb_be),
      .set_en_i   (set_en),
      .set_mask_i (req_mask),
      .set_full_i (req_full),
      .eff_lanes_o(eff_lanes[r]),
      .eff_full_o (eff_full[r]),
      .busy_o     (reg_busy[r])
    );
  end

  // R4
  grant_no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    grant |-> ((eff_lanes[req_idx] & req_mask) == '0));

endmodule

// File: tb/byte_hazard_tracker_tb_top.sv
`timescale 1ns/1ps
module byte_hazard_tracker_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid, req_write, req_full;
  logic [2:0] req_idx;
  logic [7:0] req_lanes;
  logic       grant;
  logic       wb_valid;
  logic [2:0] wb_idx;
  logic [7:0] wb_be;
  logic [7:0] reg_busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_lane [8];
  logic       m_full [8];

  always #10 clk = ~clk;

  byte_hazard_tracker dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_idx(req_idx), .req_write(req_write),
    .req_full(req_full), .req_lanes(req_lanes), .grant(grant),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_be(wb_be),
    .reg_busy(reg_busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_eff(input int r);
    logic [7:0] clr;
    clr = (wb_valid && wb_idx == 3'(r)) ? wb_be : 8'h00;
    return m_lane[r] & ~clr;
  endfunction

  function automatic logic [7:0] m_mask();
    return req_full ? 8'hFF : req_lanes;
  endfunction

  function automatic logic m_grant();
    logic [7:0] e;
    logic       f;
    e = m_eff(int'(req_idx));
    f = m_full[req_idx] && (e != 8'h00);
    return req_valid && (m_mask() != 8'h00) && ((e & m_mask()) == 8'h00) && !f;
  endfunction

  function automatic logic [7:0] m_busy();
    logic [7:0] b;
    for (int r = 0; r < 8; r++) b[r] = (m_lane[r] != 8'h00) || m_full[r];
    return b;
  endfunction

  task automatic m_update();
    logic       g;
    logic [7:0] e [8];
    logic       f [8];
    g = m_grant();
    for (int r = 0; r < 8; r++) begin
      e[r] = m_eff(r);
      f[r] = m_full[r] && (e[r] != 8'h00);
      if (g && req_write && req_idx == 3'(r)) begin
        e[r] = e[r] | m_mask();
        f[r] = f[r] | req_full;
      end
    end
    for (int r = 0; r < 8; r++) begin
      m_lane[r] = e[r];
      m_full[r] = f[r];
    end
  endtask

  task automatic op(input logic v, input logic [2:0] idx, input logic wr,
                    input logic full, input logic [7:0] lanes,
                    input logic wbv, input logic [2:0] wbi, input logic [7:0] wbe,
                    input int expg, input string tag);
    logic eg;
    @(negedge clk);
    chk({tag, " busy"}, 32'(reg_busy), 32'(m_busy()));
    req_valid = v; req_idx = idx; req_write = wr; req_full = full; req_lanes = lanes;
    wb_valid = wbv; wb_idx = wbi; wb_be = wbe;
    #1;
    eg = (expg >= 0) ? expg[0] : m_grant();
    chk({tag, " grant"}, 32'(grant), 32'(eg));
    @(posedge clk);
    m_update();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req_valid = 0; req_idx = 0; req_write = 0; req_full = 0; req_lanes = 0;
    wb_valid = 0; wb_idx = 0; wb_be = 0;
    repeat (2) @(posedge clk);
    for (int r = 0; r < 8; r++) begin m_lane[r] = 8'h00; m_full[r] = 1'b0; end
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ord [8];
    ord = '{5, 2, 7, 0, 3, 6, 1, 4};
    void'($urandom(32'd20201019));
    do_reset();

    // R1: reset state
    chk("R1 busy after reset", 32'(reg_busy), 32'h0);
    op(1, 0, 1, 1, 8'h00, 0, 0, 0, 1, "R1 full write granted after reset");
    op(0, 0, 0, 0, 8'h00, 1, 0, 8'hFF, 0, "R10 idle writeback");

    // R2, R3, R4
    op(1, 2, 1, 0, 8'h01, 0, 0, 0, 1, "R2 byte write lane0");
    op(1, 2, 1, 0, 8'h02, 0, 0, 0, 1, "R3 disjoint write lane1");
    op(1, 2, 0, 0, 8'h01, 0, 0, 0, 0, "R4 same-lane read stalls");
    op(1, 2, 1, 0, 8'h03, 0, 0, 0, 0, "R4 overlapping write stalls");
    chk("R2 reg_busy bit2", 32'(reg_busy[2]), 32'h1);

    // R5
    op(1, 2, 0, 1, 8'h00, 0, 0, 0, 0, "R5 full read blocked");
    op(0, 0, 0, 0, 8'h00, 1, 2, 8'h01, 0, "R7 wb lane0");
    op(1, 2, 0, 1, 8'h00, 0, 0, 0, 0, "R5 full read blocked by one lane");
    op(1, 2, 1, 1, 8'h00, 0, 0, 0, 0, "R5 full write blocked by one lane");
    op(0, 0, 0, 0, 8'h00, 1, 2, 8'h02, 0, "R7 wb lane1");
    op(1, 2, 0, 1, 8'h00, 0, 0, 0, 1, "R5 full read after all lanes clear");

    // R6
    op(1, 3, 1, 1, 8'h00, 0, 0, 0, 1, "R6 full write");
    op(0, 0, 0, 0, 8'h00, 1, 3, 8'h0F, 0, "R6 partial wb");
    op(1, 3, 0, 0, 8'h01, 0, 0, 0, 0, "R6 written-back lane still stalls");
    op(0, 0, 0, 0, 8'h00, 1, 3, 8'hF0, 0, "R6 final wb");
    op(1, 3, 0, 0, 8'h01, 0, 0, 0, 1, "R6 lane free after full clear");

    // R7
    op(1, 4, 1, 0, 8'hFF, 0, 0, 0, 1, "R7 all-lane byte write");
    op(0, 0, 0, 0, 8'h00, 1, 4, 8'h0F, 0, "R7 wb low half");
    op(1, 4, 0, 0, 8'h10, 0, 0, 0, 0, "R7 uncleared lane4 stalls");
    op(1, 4, 0, 0, 8'h01, 0, 0, 0, 1, "R7 cleared lane0 granted");

    // R8
    op(1, 5, 1, 0, 8'h04, 0, 0, 0, 1, "R8 write lane2");
    op(1, 5, 1, 0, 8'h04, 1, 5, 8'h04, 1, "R8 wb and write same lane");
    op(1, 5, 0, 0, 8'h04, 0, 0, 0, 0, "R8 lane pending after set");

    // R9
    op(1, 6, 0, 1, 8'h00, 0, 0, 0, 1, "R9 full read");
    chk("R9 read leaves reg6 idle", 32'(reg_busy[6]), 32'h0);
    op(1, 6, 1, 1, 8'h00, 0, 0, 0, 1, "R9 full write after read");

    // R10
    op(0, 1, 1, 1, 8'h00, 0, 0, 0, 0, "R10 not valid");
    op(1, 1, 1, 0, 8'h00, 0, 0, 0, 0, "R10 empty mask");
    chk("R10 reg1 unchanged", 32'(reg_busy[1]), 32'h0);

    // R11: eight lane reads out of order
    for (int l = 0; l < 8; l++)
      op(1, 7, 1, 0, 8'(1 << l), 0, 0, 0, 1, "R11 lane write");
    for (int i = 0; i < 8; i++) begin
      op(0, 0, 0, 0, 8'h00, 1, 7, 8'(1 << ord[i]), 0, "R11 wb lane");
      op(1, 7, 0, 0, 8'(1 << ord[i]), 0, 0, 0, 1, "R11 released lane read");
      if (i < 7)
        op(1, 7, 0, 0, 8'(1 << ord[i+1]), 0, 0, 0, 0, "R11 held lane read");
    end

    // Random phase against scoreboard
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] ln;
      ln = ($urandom % 4 == 0) ? 8'($urandom) : 8'(1 << ($urandom % 8));
      op(($urandom % 4) != 0, 3'($urandom), 1'($urandom), ($urandom % 5) == 0, ln,
         ($urandom % 3) != 0, 3'($urandom), 8'($urandom), -1, "R3/R4/R7 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule